// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Bank

A bank of independent down-counting timer channels behind a small 32-bit register bus. Each channel holds a control word, an interval value and a live counter. When a channel is enabled and its selected tick arrives, the counter steps down by one. On a tick that finds the counter at zero, the channel raises its pending flag and refills the counter from the interval. In single-shot mode the channel then switches itself off. In continuous mode it keeps running and so gives a periodic event. With an interval of all ones, the inverted counter serves as a free-running up count.

Ticks reach the block as one-cycle enable pulses from three sources: a crystal-oscillator tick, a divided-PLL tick and a slow fixed tick. Channels built with a source field choose between the first two. Channels built without one always count the slow tick. Channels built with a prescale field divide the chosen tick by a power of two. One shared register holds a per-channel interrupt enable, and another holds the pending flags, each cleared by writing a one to it. The level interrupt output is high while any enabled channel has its pending flag set.

Top module: `timer_bank`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Offset 0x00 holds the interrupt enables and offset 0x04 holds the pending flags, with bit n belonging to channel n. `irq_o` is high exactly when some channel has both its enable bit and its pending bit set.
- R3: Writing 0x04 clears each pending bit written as 1 and leaves the bits written as 0 unchanged, so writing back a value just read clears every bit that read as set. An expiry in the same cycle as a clear of that bit leaves the bit set.
- R4: Channel n has its control word at 0x10+0x10·n, its interval at +0x4 and its counter (read-only) at +0x8. The interval reads back as written. Any address that is not 4-byte aligned, or that decodes to no register, reads zero and writes nothing.
- R5: Control bit layout: bit 0 enable, bit 1 reload, bits [3:2] source, bits [6:4] prescale, bit 7 single-shot. A reload bit written as 1 reads 1 in the cycle after the write. At the next clock edge the counter takes the interval and the reload bit reads 0.
- R6: An enabled channel decrements by one on each effective tick of its source: 1 selects the oscillator tick, 2 selects the PLL tick, and 0 or 3 stop counting. A tick from a source that is not selected has no effect.
- R7: On an effective tick with the counter at zero, the channel sets its pending bit and reloads the interval, so expiries come every interval+1 ticks. In continuous mode (bit 7 = 0) the enable bit stays set.
- R8: In single-shot mode (bit 7 = 1), an expiry also clears the enable bit. After that the counter holds the interval value.
- R9: On a channel with a prescale field value N, the counter decrements once every 2^N selected ticks. The tick divider restarts while the channel is disabled.
- R10: A channel without a source field counts the slow tick and reads bits [6:2] as zero. A channel without a prescale field reads bits [6:4] as zero. By default channels 0–3 have a source field, channel 4 does not, and only channel 0 has a prescale field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick_osc | input | 1 | Oscillator tick pulse |
| tick_pll | input | 1 | Divided-PLL tick pulse |
| tick_slow | input | 1 | Slow tick pulse for channels without a source field |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench counts a channel down to zero and then applies one more tick, because a design that expired on reaching zero instead of on the tick after it would fire one tick early. It watches the reload bit in the cycle after its write and again one cycle later, which would expose a copy that never happened or a bit that stuck high. It lands a status-register clear in the same cycle as an expiry on that channel, where a design with the wrong priority would lose the event. It sweeps the prescale over several powers of two and feeds ticks from sources the channel has not selected, where an off-by-one divider or a wrong source mux would show up as a wrong counter value.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_OSC  = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_RSV  = 2'd3
  } tick_src_e;

  // Packed from bit 7 down to bit 0.
  typedef struct packed {
    logic       oneshot;
    logic [2:0] pre;
    tick_src_e  src;
    logic       reload;
    logic       en;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_in,
  input  logic [PRE_W-1:0] shift,
  output logic             tick_out
);
  localparam int CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             hit;

  assign limit = ~({CNT_W{1'b1}} << shift);

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (tick_in) begin
      if (cnt_q >= limit) begin
        cnt_d = '0;
        hit   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_out = hit;
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit HAS_SRC = 1'b1,
  parameter bit HAS_PRE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              intv_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_osc,
  input  logic              tick_pll,
  input  logic              tick_slow,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] intv_rd,
  output logic [DATA_W-1:0] cur_rd,
  output logic              expire
);
  chan_ctrl_t        ctrl_q, ctrl_d, ctrl_wr;
  logic [DATA_W-1:0] intv_q, intv_d, cur_q, cur_d;
  logic              raw_tick, eff_tick;

  generate
    if (HAS_SRC) begin : g_src
      logic unused_slow;
      assign unused_slow = tick_slow;
      always_comb begin
        case (ctrl_q.src)
          SRC_OSC: raw_tick = tick_osc;
          SRC_PLL: raw_tick = tick_pll;
          default: raw_tick = 1'b0;
        endcase
      end
    end else begin : g_fixed
      logic unused_fast;
      assign unused_fast = tick_osc ^ tick_pll;
      assign raw_tick = tick_slow;
    end

    if (HAS_PRE) begin : g_pre
      timer_prescaler #(.PRE_W(3)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.en),
        .tick_in  (raw_tick),
        .shift    (ctrl_q.pre),
        .tick_out (eff_tick)
      );
    end else begin : g_nopre
      assign eff_tick = raw_tick & ctrl_q.en;
    end
  endgenerate

  // Fields the channel does not implement are stored as zero.
  always_comb begin
    ctrl_wr = chan_ctrl_t'(wdata[CTRL_W-1:0]);
    if (!HAS_SRC) ctrl_wr.src = SRC_NONE;
    if (!HAS_PRE) ctrl_wr.pre = '0;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    intv_d = intv_q;
    cur_d  = cur_q;
    expire = 1'b0;
    if (ctrl_q.reload) begin
      cur_d         = intv_q;
      ctrl_d.reload = 1'b0;
    end else if (ctrl_q.en && eff_tick) begin
      if (cur_q == '0) begin
        expire = 1'b1;
        cur_d  = intv_q;
        if (ctrl_q.oneshot) ctrl_d.en = 1'b0;
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
    if (ctrl_we) ctrl_d = ctrl_wr;
    if (intv_we) intv_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cur_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      intv_q <= intv_d;
      cur_q  <= cur_d;
    end
  end

  assign ctrl_rd = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  assign intv_rd = intv_q;
  assign cur_rd  = cur_q;
endmodule

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int          NUM_CH   = 5,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int unsigned SRC_MASK = 32'h0000_000F,
  parameter int unsigned PRE_MASK = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_osc,
  input  logic              tick_pll,
  input  logic              tick_slow,
  output logic              irq_o
);
  localparam int PAGE_W = ADDR_W - 4;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [PAGE_W-1:0] page;
  logic [1:0]        word;
  logic              aligned, glob_hit;
  logic [NUM_CH-1:0] ien_q, ien_d, pend_q, pend_d, chan_exp, ch_hit;
  logic [DATA_W-1:0] ctrl_rd [NUM_CH];
  logic [DATA_W-1:0] intv_rd [NUM_CH];
  logic [DATA_W-1:0] cur_rd  [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign page     = bus_addr[ADDR_W-1:4];
  assign word     = bus_addr[3:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign glob_hit = aligned && (page == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      assign ch_hit[gi] = aligned && (page == PAGE_W'(gi + 1));
      timer_channel #(
        .DATA_W  (DATA_W),
        .HAS_SRC (SRC_MASK[gi]),
        .HAS_PRE (PRE_MASK[gi])
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .ctrl_we   (bus_wr && ch_hit[gi] && word == 2'd0),
        .intv_we   (bus_wr && ch_hit[gi] && word == 2'd1),
        .wdata     (bus_wdata),
        .tick_osc  (tick_osc),
        .tick_pll  (tick_pll),
        .tick_slow (tick_slow),
        .ctrl_rd   (ctrl_rd[gi]),
        .intv_rd   (intv_rd[gi]),
        .cur_rd    (cur_rd[gi]),
        .expire    (chan_exp[gi])
      );
    end
  endgenerate

  always_comb begin
    ien_d  = ien_q;
    pend_d = pend_q;
    if (bus_wr && glob_hit && word == 2'd0) ien_d = bus_wdata[NUM_CH-1:0];
    if (bus_wr && glob_hit && word == 2'd1) pend_d = pend_q & ~bus_wdata[NUM_CH-1:0];
    pend_d = pend_d | chan_exp;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (glob_hit) begin
      if (word == 2'd0) bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, ien_q};
      if (word == 2'd1) bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, pend_q};
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        case (word)
          2'd0:    bus_rdata = ctrl_rd[i];
          2'd1:    bus_rdata = intv_rd[i];
          2'd2:    bus_rdata = cur_rd[i];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_o = |(pend_q & ien_q);
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic [NUM_CH-1:0] pend_q,
  input logic [NUM_CH-1:0] chan_exp
);
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4)) |=>
      ((pend_q & $past(bus_wdata[NUM_CH-1:0] & ~chan_exp)) == '0));

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_exp) |=> ((pend_q & $past(chan_exp)) == $past(chan_exp)));

  // R7
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(chan_exp)) == '0);

  // R2
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q != '0));
endmodule

bind timer_bank timer_bank_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .pend_q    (pend_q),
  .chan_exp  (chan_exp)
);

// File: tb/timer_bank_test.sv
module timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_osc = 1'b0, tick_pll = 1'b0, tick_slow = 1'b0;
  logic        irq_o;
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  timer_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_osc(tick_osc),
    .tick_pll(tick_pll), .tick_slow(tick_slow), .irq_o(irq_o)
  );

  function automatic logic [7:0] ca(input int c, input int r);
    return 8'(8'h10 + c * 16 + r * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // which: 0 osc, 1 pll, 2 slow
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_osc = (which == 0); tick_pll = (which == 1); tick_slow = (which == 2);
      @(negedge clk);
      tick_osc = 1'b0; tick_pll = 1'b0; tick_slow = 1'b0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values, all registers
    rdchk("R1 ien", 8'h00, 0);
    rdchk("R1 pend", 8'h04, 0);
    for (int c = 0; c < 5; c++)
      for (int r = 0; r < 3; r++) rdchk("R1 chan reg", ca(c, r), 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R4 interval readback, unaligned ignored
    for (int c = 0; c < 5; c++) wr(ca(c, 1), 32'hA500_0000 + c * 32'h111);
    for (int c = 0; c < 5; c++) rdchk("R4 interval", ca(c, 1), 32'hA500_0000 + c * 32'h111);
    wr(8'h15, 32'h1234);
    rdchk("R4 unaligned write", ca(0, 1), 32'hA500_0000);
    rdchk("R4 unaligned read", 8'h15, 0);
    rdchk("R4 unmapped read", 8'hF0, 0);

    // R10 field masking per channel
    for (int c = 0; c < 5; c++) wr(ca(c, 0), 32'hFD);
    rdchk("R10 ch0 full", ca(0, 0), 32'hFD);
    rdchk("R10 ch1 no prescale", ca(1, 0), 32'h8D);
    rdchk("R10 ch4 no source", ca(4, 0), 32'h81);
    for (int c = 0; c < 5; c++) wr(ca(c, 0), 0);

    // R5 reload timing
    wr(ca(1, 1), 10);
    wr(ca(1, 0), 32'h2);
    rdchk("R5 reload bit set", ca(1, 0), 32'h2);
    rdchk("R5 counter before copy", ca(1, 2), 0);
    @(negedge clk);
    rdchk("R5 reload bit clear", ca(1, 0), 0);
    rdchk("R5 counter copied", ca(1, 2), 10);

    // R6 R7 continuous on oscillator
    wr(ca(1, 0), 32'h5);
    pulse(0, 3);
    rdchk("R6 decrement", ca(1, 2), 7);
    pulse(1, 4);
    rdchk("R6 unselected source ignored", ca(1, 2), 7);
    pulse(0, 7);
    rdchk("R7 at zero no pend", ca(1, 2), 0);
    rdchk("R7 at zero no pend flag", 8'h04, 0);
    pulse(0, 1);
    rdchk("R7 pend set", 8'h04, 32'h2);
    rdchk("R7 reloaded", ca(1, 2), 10);
    rdchk("R7 still enabled", ca(1, 0), 32'h5);
    chk("R2 irq masked", {31'd0, irq_o}, 0);
    wr(8'h00, 32'h2);
    #1 chk("R2 irq raised", {31'd0, irq_o}, 1);
    wr(8'h04, 32'h2);
    rdchk("R3 cleared", 8'h04, 0);
    chk("R2 irq dropped", {31'd0, irq_o}, 0);
    wr(ca(1, 0), 0);

    // R6 source 0 and source 2
    wr(ca(2, 1), 5);
    wr(ca(2, 0), 32'h2);
    wr(ca(2, 0), 32'h1);
    pulse(0, 2); pulse(1, 2);
    rdchk("R6 source 0 holds", ca(2, 2), 5);
    wr(ca(2, 0), 32'h9);
    pulse(1, 3); pulse(0, 2);
    rdchk("R6 pll source", ca(2, 2), 2);
    wr(ca(2, 0), 0);

    // R8 single-shot
    wr(ca(3, 1), 2);
    wr(ca(3, 0), 32'h2);
    wr(ca(3, 0), 32'h85);
    pulse(0, 3);
    rdchk("R8 pend", 8'h04, 32'h8);
    rdchk("R8 enable cleared", ca(3, 0), 32'h84);
    pulse(0, 4);
    rdchk("R8 counter holds interval", ca(3, 2), 2);

    // R9 prescale sweep on channel 0
    wr(ca(0, 1), 100);
    for (int n = 0; n < 4; n++) begin
      wr(ca(0, 0), 32'h2);
      wr(ca(0, 0), (n << 4) | 32'h5);
      pulse(0, 3 * (1 << n));
      rdchk("R9 divided count", ca(0, 2), 97);
      pulse(0, (1 << n) - 1);
      rdchk("R9 partial period", ca(0, 2), 97);
      pulse(0, 1);
      rdchk("R9 next step", ca(0, 2), 96);
    end
    wr(ca(0, 0), 0);

    // R10 slow tick on channel 4, inverted free-running count
    wr(ca(4, 1), 32'hFFFF_FFFF);
    wr(ca(4, 0), 32'h2);
    wr(ca(4, 0), 32'h1);
    pulse(0, 2); pulse(1, 2);
    rdchk("R10 fast ticks ignored", ca(4, 2), 32'hFFFF_FFFF);
    pulse(2, 5);
    bus_addr = ca(4, 2); #1;
    chk("R10 slow tick up count", ~bus_rdata, 5);
    wr(ca(4, 0), 0);

    // R3 write back what was read
    bus_addr = 8'h04; #1; v = bus_rdata;
    chk("R3 pending before writeback", v, 32'h8);
    wr(8'h04, v);
    rdchk("R3 writeback clears", 8'h04, 0);

    // R3 expiry wins over same-cycle clear
    wr(ca(1, 1), 0);
    wr(ca(1, 0), 32'h2);
    wr(ca(1, 0), 32'h5);
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'h2; bus_wr = 1'b1; tick_osc = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_osc = 1'b0;
    rdchk("R3 set wins", 8'h04, 32'h2);
    chk("R2 irq after set wins", {31'd0, irq_o}, 1);
    wr(ca(1, 0), 0);
    wr(8'h04, 32'h2);
    rdchk("R3 final clear", 8'h04, 0);
    chk("R2 irq final", {31'd0, irq_o}, 0);

    summary();
  end
endmodule